// File: doc/BRIEF.md
# Per-Lane Variable Vector Shifter

This block shifts every lane of a packed vector operand by its own distance. The distance for each lane comes from the matching lane of a second operand. Only the low byte of that lane counts, and it is read as a two's-complement number. A positive distance moves bits toward the most significant end. A negative distance moves bits the other way. A right move copies the sign bit in when the signed select is high and shifts in zeros when it is low. Any distance whose size reaches the lane width wipes the lane to zero.

The lane width is picked per operation by a two-bit size code (8, 16, 32 or 64 bits). A form select chooses between the full 128-bit operation and a 64-bit operation, which computes only the lower half and clears the upper half. One operation can be presented each cycle with a valid strobe. The result appears in an output register one cycle later, together with a matching valid flag.

Top module: `lane_shift_unit`

## Requirements
- R1: The shift distance for a lane is bits [7:0] of that lane of `b_vec`, read as a signed value from -128 to 127. All higher bits of a `b_vec` lane have no effect on the result.
- R2: A distance d with 0 <= d < lane width gives the `a_vec` lane shifted left by d, with zeros entering at the least significant end. A distance of 0 returns the lane unchanged.
- R3: A negative distance -m with m < lane width and `is_signed`=0 gives the lane shifted right logically by m, with zeros entering at the top.
- R4: A negative distance -m with m < lane width and `is_signed`=1 gives the lane shifted right arithmetically by m, with copies of the lane's top bit entering at the top.
- R5: When the distance's size is greater than or equal to the lane width, the lane result is all zeros. This holds for both directions and both signedness settings, and it includes the distance -128.
- R6: `elem_size` sets the lane width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. Lane i occupies bits [i*w +: w] of `a_vec`, `b_vec` and `result`.
- R7: With `wide_form`=1 all 128 bits are processed. With `wide_form`=0 only bits [63:0] are processed and `result[127:64]` is zero.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` loads on that clock edge and keeps its value through cycles in which `in_valid` is low.
- R9: While `rst_n` is low, `out_valid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| a_vec | input | 128 | Vector whose lanes are shifted |
| b_vec | input | 128 | Vector whose lane low bytes give the signed distances |
| elem_size | input | 2 | Lane width code: 8 << elem_size bits |
| is_signed | input | 1 | 1: right shifts are arithmetic; 0: logical |
| wide_form | input | 1 | 1: 128-bit operation; 0: 64-bit operation with upper half cleared |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 128 | Registered shifted vector |

## Verification
Every result is due exactly one rising edge after the operation is presented. The bench drives operands on a falling edge and holds `in_valid` for one cycle. It then samples `out_valid` and `result` on the next falling edge, half a cycle after the register loaded. The hold check repeats the same timing with `in_valid` low and new operands, and it expects the previous result to stay unchanged and `out_valid` to be low. Reset values are sampled on a falling edge while reset is still held.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
   localparam int unsigned LSH_VEC_W    = 128;
   localparam int unsigned LSH_BASE_W   = 8;
   localparam int unsigned LSH_NUM_SIZE = 4;
   localparam int unsigned LSH_AMT_W    = 8;

   typedef enum logic [1:0] {
      LSH_SZ_8  = 2'd0,
      LSH_SZ_16 = 2'd1,
      LSH_SZ_32 = 2'd2,
      LSH_SZ_64 = 2'd3
   } lsh_size_e;
endpackage

// File: rtl/lsh_lane.sv
module lsh_lane #(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned AMT_W  = 8
) (
   input  logic [LANE_W-1:0] a_lane,
   input  logic [LANE_W-1:0] b_lane,
   input  logic              is_signed,
   output logic [LANE_W-1:0] res
);
   localparam int unsigned MAG_W = AMT_W + 1;
   localparam int unsigned SH_W  = (LANE_W > 1) ? $clog2(LANE_W) : 1;

   initial begin
      assert (LANE_W >= AMT_W) else $error("lane narrower than distance field");
      assert (LANE_W < (1 << AMT_W)) else $error("lane too wide for distance field");
   end

   logic [AMT_W-1:0]  amt;
   logic              neg;
   logic [MAG_W-1:0]  mag;
   logic              too_big;
   logic [SH_W-1:0]   sh;
   logic [LANE_W-1:0] left_r;
   logic [LANE_W-1:0] logic_r;
   logic [LANE_W-1:0] arith_r;

   assign amt = b_lane[AMT_W-1:0];

   generate
      if (LANE_W > AMT_W) begin : g_hi
         logic unused_hi_bits;
         assign unused_hi_bits = ^b_lane[LANE_W-1:AMT_W];
      end
   endgenerate

   assign neg     = amt[AMT_W-1];
   assign mag     = neg ? (~{1'b1, amt}) + MAG_W'(1) : {1'b0, amt};
   assign too_big = (mag >= MAG_W'(LANE_W));
   assign sh      = mag[SH_W-1:0];

   assign left_r  = a_lane << sh;
   assign logic_r = a_lane >> sh;
   assign arith_r = $signed(a_lane) >>> sh;

   always_comb begin
      if (too_big)        res = '0;
      else if (!neg)      res = left_r;
      else if (is_signed) res = arith_r;
      else                res = logic_r;
   end
endmodule

// File: rtl/lsh_size_bank.sv
module lsh_size_bank #(
   parameter int unsigned VEC_W  = 128,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned AMT_W  = 8
) (
   input  logic [VEC_W-1:0] a_vec,
   input  logic [VEC_W-1:0] b_vec,
   input  logic             is_signed,
   output logic [VEC_W-1:0] res_vec
);
   localparam int unsigned NUM_LANES = VEC_W / LANE_W;

   initial begin
      assert (VEC_W % LANE_W == 0) else $error("vector not a whole number of lanes");
   end

   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
         lsh_lane #(
            .LANE_W (LANE_W),
            .AMT_W  (AMT_W)
         ) u_lane (
            .a_lane    (a_vec[i*LANE_W +: LANE_W]),
            .b_lane    (b_vec[i*LANE_W +: LANE_W]),
            .is_signed (is_signed),
            .res       (res_vec[i*LANE_W +: LANE_W])
         );
      end
   endgenerate
endmodule

// File: rtl/lsh_out_reg.sv
module lsh_out_reg #(
   parameter int unsigned DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] d,
   output logic              out_valid,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         q         <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) q <= d;
      end
   end
endmodule

// File: rtl/lane_shift_unit.sv
module lane_shift_unit
   import lsh_pkg::*;
#(
   parameter int unsigned VEC_W    = LSH_VEC_W,
   parameter int unsigned BASE_W   = LSH_BASE_W,
   parameter int unsigned NUM_SIZE = LSH_NUM_SIZE,
   parameter int unsigned AMT_W    = LSH_AMT_W,
   parameter int unsigned SIZE_W   = $clog2(NUM_SIZE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [VEC_W-1:0]  a_vec,
   input  logic [VEC_W-1:0]  b_vec,
   input  logic [SIZE_W-1:0] elem_size,
   input  logic              is_signed,
   input  logic              wide_form,
   output logic              out_valid,
   output logic [VEC_W-1:0]  result
);
   localparam int unsigned HALF_W = VEC_W / 2;
   localparam int unsigned MAX_W  = BASE_W << (NUM_SIZE - 1);

   initial begin
      assert (VEC_W % (2 * MAX_W) == 0 || VEC_W == MAX_W)
         else $error("vector width does not fit the widest lane");
      assert (AMT_W <= BASE_W) else $error("distance field wider than smallest lane");
      assert ((1 << SIZE_W) >= NUM_SIZE) else $error("size code too narrow");
   end

   logic [VEC_W-1:0] bank_res [NUM_SIZE];
   logic [VEC_W-1:0] sel_res;
   logic [VEC_W-1:0] masked_res;

   generate
      for (genvar s = 0; s < NUM_SIZE; s++) begin : g_bank
         lsh_size_bank #(
            .VEC_W  (VEC_W),
            .LANE_W (BASE_W << s),
            .AMT_W  (AMT_W)
         ) u_bank (
            .a_vec     (a_vec),
            .b_vec     (b_vec),
            .is_signed (is_signed),
            .res_vec   (bank_res[s])
         );
      end
   endgenerate

   always_comb begin
      sel_res = '0;
      for (int s = 0; s < NUM_SIZE; s++) begin
         if (elem_size == SIZE_W'(s)) sel_res = bank_res[s];
      end
   end

   assign masked_res = wide_form ? sel_res : {{HALF_W{1'b0}}, sel_res[HALF_W-1:0]};

   lsh_out_reg #(
      .DATA_W (VEC_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .d         (masked_res),
      .out_valid (out_valid),
      .q         (result)
   );

   // R8
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R8
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && !out_valid));

   // R7
   narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !wide_form) |=> (result[VEC_W-1:HALF_W] == '0));

   // R2
   zero_dist_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && wide_form && b_vec == '0) |=> (result == $past(a_vec)));

   // R5
   min_dist_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && elem_size == '0 && b_vec == {(VEC_W/8){8'h80}}) |=> (result == '0));
endmodule

// File: tb/lane_shift_unit_tb_top.sv
module lane_shift_unit_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] a_vec = '0;
   logic [127:0] b_vec = '0;
   logic [1:0]   elem_size = '0;
   logic         is_signed = 1'b0;
   logic         wide_form = 1'b1;
   logic         out_valid;
   logic [127:0] result;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   lane_shift_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_vec(a_vec), .b_vec(b_vec),
      .elem_size(elem_size), .is_signed(is_signed), .wide_form(wide_form),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic [127:0] ref_shift(logic [127:0] a, logic [127:0] b,
                                              logic [1:0] sz, logic sgn, logic wide);
      logic [127:0] r = '0;
      int w = 8 << sz;
      int n = (wide ? 128 : 64) / w;
      logic [63:0] m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
      for (int i = 0; i < n; i++) begin
         logic [63:0] av = 64'((a >> (i * w))) & m;
         logic signed [7:0] amt = b[i*w +: 8];
         int k = amt;
         logic [63:0] lv;
         if (k >= 0) lv = (k >= w) ? 64'd0 : ((av << k) & m);
         else if (-k >= w) lv = 64'd0;
         else if (sgn) begin
            if (av[w-1]) av = av | ~m;
            lv = 64'($signed(av) >>> (-k)) & m;
         end else lv = av >> (-k);
         r = r | (128'(lv) << (i * w));
      end
      return r;
   endfunction

   function automatic logic [127:0] mk_b(logic [1:0] sz, logic [7:0] amt, logic [127:0] junk);
      logic [127:0] r = junk;
      int bpl = 1 << sz;
      for (int j = 0; j < 16; j++)
         if (j % bpl == 0) r[j*8 +: 8] = amt;
      return r;
   endfunction

   task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(logic [127:0] a, logic [127:0] b, logic [1:0] sz,
                         logic sgn, logic wide, string tag);
      @(negedge clk);
      a_vec = a; b_vec = b; elem_size = sz; is_signed = sgn; wide_form = wide;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " R8 valid"}, {127'd0, out_valid}, 128'd1);
      check(tag, result, ref_shift(a, b, sz, sgn, wide));
   endtask

   initial begin : watchdog
      while (cycles < 100000) @(posedge clk) cycles++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin : stim
      logic [127:0] pa = 128'h8123_4567_F9AB_CDEF_7E5A_C3B1_0F96_D248;
      logic [127:0] junk = 128'hA5C3_7F01_E2D4_3B96_5A0C_F18E_6D27_B4E9;
      logic [127:0] held;
      int dlist [10];
      void'($urandom(32'd7919));
      repeat (3) @(negedge clk);
      // R9
      check("R9 reset valid", {127'd0, out_valid}, 128'd0);
      check("R9 reset result", result, 128'd0);
      @(negedge clk); rst_n = 1'b1;

      for (int s = 0; s < 4; s++) begin
         int w = 8 << s;
         dlist = '{0, 1, w - 1, w, 127, -1, -(w - 1), -w, -128, 3};
         for (int sg = 0; sg < 2; sg++)
            for (int d = 0; d < 10; d++) begin
               string tag;
               int dv = dlist[d];
               if (dv == 0)               tag = "R2 zero R1 hi-bits";
               else if (dv >= w || dv <= -w) tag = "R5 out-of-range";
               else if (dv > 0)           tag = "R2 left";
               else if (sg == 1)          tag = "R4 arith";
               else                       tag = "R3 logical";
               run_op(pa, mk_b(2'(s), 8'(dv), junk), 2'(s), sg[0], 1'b1,
                      $sformatf("%s R6 size%0d d=%0d", tag, s, dv));
            end
      end

      // R7 narrow form clears upper half
      for (int s = 0; s < 4; s++)
         run_op(pa, mk_b(2'(s), 8'hFE, junk), 2'(s), 1'b1, 1'b0, "R7 narrow");

      // R1 upper bits of B lanes differ but give same result
      run_op(pa, mk_b(2'd3, 8'd5, 128'd0), 2'd3, 1'b0, 1'b1, "R1 clean-b");
      run_op(pa, mk_b(2'd3, 8'd5, '1), 2'd3, 1'b0, 1'b1, "R1 ones-b");

      // R8 hold when idle
      held = result;
      @(negedge clk);
      a_vec = ~pa; b_vec = '0; in_valid = 1'b0;
      @(negedge clk);
      check("R8 hold result", result, held);
      check("R8 idle valid", {127'd0, out_valid}, 128'd0);

      // R6 random mix
      for (int t = 0; t < 400; t++) begin
         logic [127:0] ra = {$urandom, $urandom, $urandom, $urandom};
         logic [127:0] rb = {$urandom, $urandom, $urandom, $urandom};
         run_op(ra, rb, 2'($urandom), 1'($urandom), 1'($urandom), "R6 random");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule